// File: doc/BRIEF.md
# Cache-Line Byte-Enable Sequencer

This block turns a memory region, given as a start address, a byte count and a transfer direction, into a stream of dword beats. Each beat carries a dword-aligned address, a 4-bit byte-enable mask, and two strobes. One strobe marks the last dword of a 32-byte cache line and the other marks the last dword of the region. A bus-master engine starts the block with a one-cycle pulse and then drains beats through a ready/valid handshake. It issues one burst per cache line and ends each burst at a line boundary.

Reads always fetch whole dwords. Address bit 1 is dropped and every lane is enabled. Writes honour the halfword offset, so a start address with bit 1 set disables the two low lanes of the first dword. The final dword of a write enables only the lanes that still hold valid data. A byte count of zero stands for a full 65536-byte region.

Top module: `be_gen`

## Requirements
- R1: After reset, `idle` is 1 and `out_valid` is 0.
- R2: A `start` pulse seen while `idle` is 1 is accepted at that clock edge. In the following cycle `out_valid` is 1 and `out_addr` equals `start_addr` with bits 1:0 cleared.
- R3: For a read (`is_write` = 0), `out_be` is 4'b1111 on every beat. `out_be` is active high, and bit 0 is the lowest byte lane.
- R4: For a write whose start address has bit 1 set, the first beat disables lanes 0 and 1 (mask 4'b1100, or that mask ANDed with the R5 tail when the region fits in one dword).
- R5: For a write, the last beat's mask follows the low two bits of (start + count): 0 gives 4'b1111, 1 gives 4'b0001, 2 gives 4'b0011 and 3 gives 4'b0111. All other beats except a R4 first beat are 4'b1111.
- R6: Successive beats step `out_addr` by 4. They run from the aligned start dword to the dword holding the region's last byte, and every address has bits 1:0 at zero.
- R7: `out_line_last` is 1 exactly on beats whose address bits 4:2 are all ones, and on the region's final beat. A burst therefore never crosses a 32-byte boundary.
- R8: `out_region_last` is 1 only on the final beat. The cycle after that beat is accepted, `out_valid` is 0 and `idle` is 1.
- R9: A `byte_cnt` of 0 yields a 65536-byte region.
- R10: While `out_valid` is 1 and `out_ready` is 0, all beat outputs hold their values into the next cycle.
- R11: A `start` pulse while a region is in progress is ignored, and the beat sequence continues unchanged.
- R12: Over a write region, the total number of enabled lanes equals the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a region |
| start_addr | input | 32 | Region start byte address (bit 0 assumed zero) |
| byte_cnt | input | 16 | Region length in bytes, 0 means 65536 |
| is_write | input | 1 | 1 for a memory write, 0 for a read |
| idle | output | 1 | No region in progress; start is accepted |
| out_valid | output | 1 | Beat outputs are valid |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_addr | output | 32 | Dword-aligned beat address |
| out_be | output | 4 | Active-high byte enables, bit 0 = lowest lane |
| out_line_last | output | 1 | Last beat of the current cache-line burst |
| out_region_last | output | 1 | Last beat of the region |

## Verification
The first beat appears one cycle after the accepting `start` edge. Every later beat appears one cycle after the previous beat was accepted, and a stalled beat is still present in the next cycle. The region's end shows as `out_valid` low and `idle` high one cycle after the final handshake. The bench drives inputs and reads outputs on falling edges. It compares each beat against a byte-range model computed from start and count, and moves its model forward only after a falling edge at which it had raised `out_ready`. It sweeps every halfword offset in a line against counts 1 to 40 in both directions under a fixed stall pattern, then runs two full 65536-byte regions.

// File: rtl/be_gen_pkg.sv
package be_gen_pkg;

    localparam int ADDR_W = 32;
    localparam int BE_W   = 4;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic              line_last;
        logic              region_last;
    } beat_t;

    // Lanes still enabled when the first dword starts on a halfword offset.
    function automatic logic [BE_W-1:0] head_mask(input logic half_off);
        return half_off ? 4'b1100 : 4'b1111;
    endfunction

    // Lanes enabled in the final dword, given 1..4 lanes left to cover.
    function automatic logic [BE_W-1:0] tail_mask(input logic [2:0] lanes_left);
        case (lanes_left)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            3'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/be_gen_walker.sv
module be_gen_walker
    import be_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              is_write,
    input  logic              advance,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W+1:0]  lanes_left,
    output logic              first_beat,
    output logic              half_off,
    output dir_e              dir
);
    localparam int REM_W = CNT_W + 2;
    localparam logic [REM_W-1:0] FULL_REGION = REM_W'(1) << CNT_W;
    localparam logic [REM_W-1:0] DWORD_LANES = REM_W'(4);

    logic [REM_W-1:0] region_len;
    logic [REM_W-1:0] lead_lanes;

    always_comb begin
        region_len = (byte_cnt == '0) ? FULL_REGION : REM_W'(byte_cnt);
        lead_lanes = start_addr[1] ? REM_W'(2) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            cur_addr   <= '0;
            lanes_left <= '0;
            first_beat <= 1'b0;
            half_off   <= 1'b0;
            dir        <= DIR_READ;
        end else if (!active) begin
            if (start) begin
                active     <= 1'b1;
                cur_addr   <= start_addr & ~ADDR_W'(3);
                lanes_left <= region_len + lead_lanes;
                first_beat <= 1'b1;
                half_off   <= start_addr[1];
                dir        <= is_write ? DIR_WRITE : DIR_READ;
            end
        end else if (advance) begin
            if (lanes_left <= DWORD_LANES) begin
                active <= 1'b0;
            end else begin
                cur_addr   <= cur_addr + ADDR_W'(4);
                lanes_left <= lanes_left - DWORD_LANES;
                first_beat <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/be_gen_lanes.sv
module be_gen_lanes
    import be_gen_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W+1:0]  lanes_left,
    input  logic              first_beat,
    input  logic              half_off,
    input  dir_e              dir,
    output beat_t             beat
);
    localparam int REM_W      = CNT_W + 2;
    localparam int LINE_IDX_W = $clog2(LINE_BYTES / 4);

    logic             at_end;
    logic [BE_W-1:0]  front;
    logic [BE_W-1:0]  back;

    always_comb begin
        at_end = (lanes_left <= REM_W'(4));
        front  = head_mask(first_beat && half_off);
        back   = at_end ? tail_mask(lanes_left[2:0]) : 4'b1111;

        beat.addr        = cur_addr;
        beat.region_last = at_end;
        beat.line_last   = at_end || (&cur_addr[LINE_IDX_W+1:2]);
        beat.be          = (dir == DIR_WRITE) ? (front & back) : 4'b1111;
    end

endmodule

// File: rtl/be_gen.sv
module be_gen
    import be_gen_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              is_write,
    output logic              idle,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BE_W-1:0]   out_be,
    output logic              out_line_last,
    output logic              out_region_last
);
    logic              active;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W+1:0]  lanes_left;
    logic              first_beat;
    logic              half_off;
    dir_e              dir;
    beat_t             beat;

    be_gen_walker #(.CNT_W(CNT_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .byte_cnt   (byte_cnt),
        .is_write   (is_write),
        .advance    (active && out_ready),
        .active     (active),
        .cur_addr   (cur_addr),
        .lanes_left (lanes_left),
        .first_beat (first_beat),
        .half_off   (half_off),
        .dir        (dir)
    );

    be_gen_lanes #(.CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)) u_lanes (
        .cur_addr   (cur_addr),
        .lanes_left (lanes_left),
        .first_beat (first_beat),
        .half_off   (half_off),
        .dir        (dir),
        .beat       (beat)
    );

    always_comb begin
        idle            = !active;
        out_valid       = active;
        out_addr        = beat.addr;
        out_be          = beat.be;
        out_line_last   = beat.line_last;
        out_region_last = beat.region_last;
    end

endmodule

// File: rtl/be_gen_checker.sv
module be_gen_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        is_write,
    input logic        idle,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_addr,
    input logic [3:0]  out_be,
    input logic        out_line_last,
    input logic        out_region_last
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst)               wr_q <= 1'b0;
        else if (start && idle) wr_q <= is_write;
    end

    assert_start_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (start && idle) |=> out_valid);

    assert_read_full_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !wr_q) |-> (out_be == 4'b1111));

    assert_be_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_be != 4'b0000));

    assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[1:0] == 2'b00));

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_region_last) |=>
            (out_valid && out_addr == $past(out_addr) + 32'd4));

    assert_end_closes_line_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_region_last) |-> out_line_last);

    assert_done_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_region_last) |=> (!out_valid && idle));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_be) &&
             $stable(out_line_last) && $stable(out_region_last)));

endmodule

bind be_gen be_gen_checker u_be_gen_checker (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .is_write        (is_write),
    .idle            (idle),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_addr        (out_addr),
    .out_be          (out_be),
    .out_line_last   (out_line_last),
    .out_region_last (out_region_last)
);

// File: tb/be_gen_bench.sv
`timescale 1ns/1ps
module be_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic        is_write = 1'b0;
    logic        out_ready = 1'b0;
    logic        idle, out_valid, out_line_last, out_region_last;
    logic [31:0] out_addr;
    logic [3:0]  out_be;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int stall_ctr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    be_gen u_be_gen (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .is_write(is_write), .idle(idle),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_be(out_be), .out_line_last(out_line_last),
        .out_region_last(out_region_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Runs one region of n bytes (1..65536) and compares every beat with a byte-range model.
    task automatic run_xfer(input longint a, input longint n, input bit wr, input bit inject);
        longint s, e, d, first_dw, last_dw, lanes_total;
        logic [3:0] exp_be;
        bit exp_ll, exp_rl, was_stall;
        int beats;
        s = a;
        e = a + n;
        first_dw = s & ~longint'(3);
        last_dw  = (e - 1) & ~longint'(3);
        @(negedge clk);
        chk(idle == 1'b1, "R2", "idle before start", idle, 1);
        start      = 1'b1;
        start_addr = a[31:0];
        byte_cnt   = n[15:0];
        is_write   = wr;
        out_ready  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(out_valid == 1'b1, "R2", "first beat valid", out_valid, 1);
        chk(out_addr == first_dw[31:0], "R2", "first beat addr", out_addr, first_dw);
        d = first_dw;
        lanes_total = 0;
        beats = 0;
        was_stall = 1'b0;
        forever begin
            for (int i = 0; i < 4; i++)
                exp_be[i] = wr ? ((d + i >= s) && (d + i < e)) : 1'b1;
            exp_rl = (d == last_dw);
            exp_ll = exp_rl || (((d >> 2) & 7) == 7);
            if (was_stall) begin
                chk(out_valid && out_addr == d[31:0] && out_be == exp_be, "R10",
                    "held beat addr", out_addr, d);
            end else begin
                chk(out_valid == 1'b1, "R6", "beat valid", out_valid, 1);
                chk(out_addr == d[31:0], "R6", "beat addr", out_addr, d);
                if (!wr)
                    chk(out_be == exp_be, "R3", "read be", out_be, exp_be);
                else if (d == first_dw && s[1])
                    chk(out_be == exp_be, "R4", "write head be", out_be, exp_be);
                else if (exp_rl)
                    chk(out_be == exp_be, "R5", "write tail be", out_be, exp_be);
                else
                    chk(out_be == exp_be, "R5", "write body be", out_be, exp_be);
                chk(out_line_last == exp_ll, "R7", "line_last", out_line_last, exp_ll);
                chk(out_region_last == exp_rl, "R8", "region_last", out_region_last, exp_rl);
            end
            stall_ctr++;
            out_ready = ((stall_ctr % 5) != 3);
            if (inject && beats == 2 && out_ready) begin
                start      = 1'b1;
                start_addr = 32'hDEAD_0000;
                byte_cnt   = 16'd7;
                is_write   = ~wr;
            end
            @(negedge clk);
            start = 1'b0;
            if (out_ready) begin
                was_stall = 1'b0;
                for (int i = 0; i < 4; i++) lanes_total += exp_be[i];
                beats++;
                if (exp_rl) break;
                d += 4;
            end else begin
                was_stall = 1'b1;
            end
        end
        out_ready = 1'b0;
        chk(!out_valid && idle, "R8", "idle after last beat", {out_valid, idle}, 2'b01);
        if (wr)
            chk(lanes_total == n, "R12", "enabled lane total", lanes_total, n);
        if (inject)
            chk(beats == (last_dw - first_dw) / 4 + 1, "R11", "beats with ignored start",
                beats, (last_dw - first_dw) / 4 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(idle == 1'b1, "R1", "idle in reset", idle, 1);
        chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1 && out_valid == 1'b0, "R1", "state after reset",
            {idle, out_valid}, 2'b10);

        // Sweep every halfword offset within a line against counts 1..40, both directions.
        for (int off = 0; off < 32; off += 2)
            for (int n = 1; n <= 40; n++)
                for (int wr = 0; wr < 2; wr++)
                    run_xfer(64'h1000_0000 + 64 * n + off, n, wr[0], 1'b0);

        // R11: start pulses during a busy region are ignored.
        run_xfer(64'h2000_0016, 37, 1'b1, 1'b1);
        run_xfer(64'h2000_0004, 29, 1'b0, 1'b1);

        // R9: zero count means 65536 bytes.
        run_xfer(64'h3000_0000, 65536, 1'b0, 1'b0);
        run_xfer(64'h3001_0002, 65536, 1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule